// File: doc/BRIEF.md
# Datapath Bus Crossbar with Memory-Mapped I/O Window

This block is the routing front end of a small 8-bit stored-program core. It chooses the 8-bit address from one of two sources: the program counter or the memory pointer. It then checks whether that address falls inside a fixed window at the top of the address space. Inside the window, reads take their data from the external input port and writes go to the outside through a registered output port. Outside the window, reads and writes use a 256-byte internal RAM. A four-way multiplexer then builds the register input bus from the ALU result, the stack output, the immediate value or the internal input bus.

A read from the window can arrive before the external side has valid data. When that happens the block raises a stall. The stall holds the program counter advance and the register write-enable, which the control unit passes through this block. The stall stays until the external side raises its data-valid input. The controller drives the selects, the read and write requests and the write data each cycle. Reset is synchronous. While reset is high, the block forces program-counter addressing and the ALU source, and it blocks every write.

Top module: `bus_xbar_mmio`

## Requirements
- R1: `addr_out` equals `pc_val` when `addr_sel` is 0 and `mptr_val` when `addr_sel` is 1.
- R2: `io_active` is high exactly when `addr_out` lies in 0xFC..0xFF (upper six address bits all ones).
- R3: `int_in_bus` equals `ext_in` while `io_active` is high; otherwise it equals the RAM byte stored at `addr_out`, read combinationally.
- R4: `rin_bus` selects by `rin_sel`: 0 gives `alu_val`, 1 gives `stack_val`, 2 gives `imm_val`, 3 gives `int_in_bus`.
- R5: `wr_active` equals `mem_wr` AND `io_active` outside reset. On a clock edge where `wr_active` is high, `ext_out` loads `wr_data`. At every other edge it keeps its value, so writes outside the window do not change it.
- R6: When `mem_wr` is high and the address is outside the window, `wr_data` is stored into RAM at `addr_out` on the clock edge. It reads back from the next cycle onward. A stall does not block writes.
- R7: `stall` is high exactly when `mem_rd` is high, `io_active` is high and `io_en` is low. While `stall` is high, `pc_inc_out` and `reg_we_out` are low. Otherwise they equal `pc_inc_in` and `reg_we_in`.
- R8: While `rst` is high, `addr_out` follows `pc_val`, `rin_bus` follows `alu_val`, and `wr_active` is low. No RAM write takes place. `ext_out` is 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_sel | input | 1 | Address source: 0 program counter, 1 memory pointer |
| rin_sel | input | 2 | Register input source: 0 ALU, 1 stack, 2 immediate, 3 internal input |
| pc_val | input | 8 | Program counter value |
| mptr_val | input | 8 | Memory pointer value |
| alu_val | input | 8 | ALU result |
| stack_val | input | 8 | Stack top value |
| imm_val | input | 8 | Immediate value |
| wr_data | input | 8 | Data for a memory or external write |
| mem_wr | input | 1 | Write request at the selected address |
| mem_rd | input | 1 | Read request at the selected address |
| ext_in | input | 8 | External input data |
| io_en | input | 1 | External input data valid |
| pc_inc_in | input | 1 | Program counter advance request from control |
| reg_we_in | input | 1 | Register write-enable request from control |
| addr_out | output | 8 | Selected address |
| io_active | output | 1 | Selected address is in the external window |
| wr_active | output | 1 | External write strobe |
| ext_out | output | 8 | Registered data last written to the external window |
| int_in_bus | output | 8 | Internal input bus (RAM or external) |
| rin_bus | output | 8 | Register input bus |
| stall | output | 1 | External read waiting for valid data |
| pc_inc_out | output | 1 | Gated program counter advance |
| reg_we_out | output | 1 | Gated register write-enable |

## Verification
Two functions can fall in the same cycle: a stalled external read and a write to the window. The test issues `mem_rd` and `mem_wr` together at a window address while `io_en` is low. It then confirms three things: the stall gates `pc_inc_out` and `reg_we_out`, `wr_active` still pulses, and `ext_out` takes the write data at the next edge. A second case is a RAM write followed at once by a read through `rin_sel` 3. This case shows that the write lands at the edge and the combinational read returns the new byte in the very next cycle. A behavioural model holds RAM contents in an array and judges every output on every cycle, including addresses 0xFB and 0xFC on either side of the window edge.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
  typedef enum logic {
    ASRC_PC   = 1'b0,
    ASRC_MPTR = 1'b1
  } asrc_e;

  typedef enum logic [1:0] {
    RSRC_ALU   = 2'd0,
    RSRC_STACK = 2'd1,
    RSRC_IMM   = 2'd2,
    RSRC_INTIN = 2'd3
  } rsrc_e;
endpackage

// File: rtl/bxm_addr_path.sv
module bxm_addr_path #(
  parameter int AW = 8,
  parameter logic [AW-1:0] WIN_BASE = 8'hFC,
  parameter int WIN_LOG2 = 2
) (
  input  logic          rst,
  input  bxm_pkg::asrc_e sel,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] mptr,
  output logic [AW-1:0] addr,
  output logic          hit
);
  import bxm_pkg::*;

  localparam int TAG_W = AW - WIN_LOG2;
  localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[AW-1:WIN_LOG2];

  asrc_e eff_sel;

  function automatic logic tag_match(input logic [AW-1:0] a);
    return a[AW-1:WIN_LOG2] == BASE_TAG;
  endfunction

  always_comb begin
    eff_sel = rst ? ASRC_PC : sel;
    addr    = (eff_sel == ASRC_MPTR) ? mptr : pc;
  end

  generate
    if (WIN_LOG2 == 0) begin : g_single
      assign hit = (addr == WIN_BASE);
    end else begin : g_range
      assign hit = tag_match(addr);
    end
  endgenerate
endmodule

// File: rtl/bxm_ram.sv
module bxm_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/bxm_in_path.sv
module bxm_in_path #(
  parameter int DW = 8
) (
  input  logic          win_hit,
  input  logic          rd_req,
  input  logic          ext_valid,
  input  logic [DW-1:0] ram_q,
  input  logic [DW-1:0] ext_q,
  output logic [DW-1:0] int_in,
  output logic          hold
);
  always_comb begin
    int_in = win_hit ? ext_q : ram_q;
    hold   = win_hit & rd_req & ~ext_valid;
  end
endmodule

// File: rtl/bxm_rin_mux.sv
module bxm_rin_mux #(
  parameter int DW = 8
) (
  input  logic           rst,
  input  bxm_pkg::rsrc_e sel,
  input  logic [DW-1:0]  alu,
  input  logic [DW-1:0]  stk,
  input  logic [DW-1:0]  imm,
  input  logic [DW-1:0]  int_in,
  output logic [DW-1:0]  rin
);
  import bxm_pkg::*;

  rsrc_e eff_sel;

  always_comb begin
    eff_sel = rst ? RSRC_ALU : sel;
    unique case (eff_sel)
      RSRC_ALU:   rin = alu;
      RSRC_STACK: rin = stk;
      RSRC_IMM:   rin = imm;
      RSRC_INTIN: rin = int_in;
      default:    rin = alu;
    endcase
  end
endmodule

// File: rtl/bus_xbar_mmio.sv
module bus_xbar_mmio #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] WIN_BASE = 8'hFC,
  parameter int WIN_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_sel,
  input  logic [1:0]    rin_sel,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] mptr_val,
  input  logic [DW-1:0] alu_val,
  input  logic [DW-1:0] stack_val,
  input  logic [DW-1:0] imm_val,
  input  logic [DW-1:0] wr_data,
  input  logic          mem_wr,
  input  logic          mem_rd,
  input  logic [DW-1:0] ext_in,
  input  logic          io_en,
  input  logic          pc_inc_in,
  input  logic          reg_we_in,
  output logic [AW-1:0] addr_out,
  output logic          io_active,
  output logic          wr_active,
  output logic [DW-1:0] ext_out,
  output logic [DW-1:0] int_in_bus,
  output logic [DW-1:0] rin_bus,
  output logic          stall,
  output logic          pc_inc_out,
  output logic          reg_we_out
);
  import bxm_pkg::*;

  logic          win_hit;
  logic          ram_we;
  logic [DW-1:0] ram_q;
  logic [DW-1:0] ext_q;

  bxm_addr_path #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_addr (
    .rst  (rst),
    .sel  (asrc_e'(addr_sel)),
    .pc   (pc_val),
    .mptr (mptr_val),
    .addr (addr_out),
    .hit  (win_hit)
  );

  assign ram_we    = mem_wr & ~win_hit & ~rst;
  assign wr_active = mem_wr &  win_hit & ~rst;
  assign io_active = win_hit;

  bxm_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (addr_out),
    .wdata (wr_data),
    .rdata (ram_q)
  );

  bxm_in_path #(.DW(DW)) u_in (
    .win_hit   (win_hit),
    .rd_req    (mem_rd),
    .ext_valid (io_en),
    .ram_q     (ram_q),
    .ext_q     (ext_in),
    .int_in    (int_in_bus),
    .hold      (stall)
  );

  bxm_rin_mux #(.DW(DW)) u_rin (
    .rst    (rst),
    .sel    (rsrc_e'(rin_sel)),
    .alu    (alu_val),
    .stk    (stack_val),
    .imm    (imm_val),
    .int_in (int_in_bus),
    .rin    (rin_bus)
  );

  always_ff @(posedge clk) begin
    if (rst)            ext_q <= '0;
    else if (wr_active) ext_q <= wr_data;
  end

  assign ext_out    = ext_q;
  assign pc_inc_out = pc_inc_in & ~stall;
  assign reg_we_out = reg_we_in & ~stall;
endmodule

// File: rtl/bus_xbar_mmio_chk.sv
module bus_xbar_mmio_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] pc_val,
  input logic          io_active,
  input logic          wr_active,
  input logic          ram_we,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] ext_out,
  input logic [DW-1:0] ext_in,
  input logic [DW-1:0] int_in_bus,
  input logic          io_en,
  input logic          stall,
  input logic          pc_inc_out,
  input logic          reg_we_out
);
  assert_window_R2: assert property (@(posedge clk) disable iff (rst)
    io_active == (addr_out >= 8'hFC));

  assert_ext_source_R3: assert property (@(posedge clk) disable iff (rst)
    io_active |-> int_in_bus == ext_in);

  assert_strobe_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    wr_active |-> io_active);

  assert_ext_capture_R5: assert property (@(posedge clk) disable iff (rst)
    wr_active |=> ext_out == $past(wr_data));

  assert_ext_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_active |=> $stable(ext_out));

  assert_ram_outside_R6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !io_active && !wr_active);

  assert_stall_gate_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> !pc_inc_out && !reg_we_out);

  assert_stall_cause_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> io_active && !io_en);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |-> !wr_active && !ram_we && addr_out == pc_val);
endmodule

bind bus_xbar_mmio bus_xbar_mmio_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr_out   (addr_out),
  .pc_val     (pc_val),
  .io_active  (io_active),
  .wr_active  (wr_active),
  .ram_we     (ram_we),
  .wr_data    (wr_data),
  .ext_out    (ext_out),
  .ext_in     (ext_in),
  .int_in_bus (int_in_bus),
  .io_en      (io_en),
  .stall      (stall),
  .pc_inc_out (pc_inc_out),
  .reg_we_out (reg_we_out)
);

// File: tb/bus_xbar_mmio_bench.sv
`timescale 1ns/1ps
module bus_xbar_mmio_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr_sel = 1'b0;
  logic [1:0] rin_sel = 2'd0;
  logic [7:0] pc_val = 8'h00, mptr_val = 8'h00, alu_val = 8'h00;
  logic [7:0] stack_val = 8'h00, imm_val = 8'h00, wr_data = 8'h00, ext_in = 8'h00;
  logic       mem_wr = 1'b0, mem_rd = 1'b0, io_en = 1'b0;
  logic       pc_inc_in = 1'b0, reg_we_in = 1'b0;
  logic [7:0] addr_out, ext_out, int_in_bus, rin_bus;
  logic       io_active, wr_active, stall, pc_inc_out, reg_we_out;

  always #4 clk = ~clk;

  bus_xbar_mmio u_bus_xbar_mmio (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .rin_sel(rin_sel),
    .pc_val(pc_val), .mptr_val(mptr_val), .alu_val(alu_val),
    .stack_val(stack_val), .imm_val(imm_val), .wr_data(wr_data),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .ext_in(ext_in), .io_en(io_en),
    .pc_inc_in(pc_inc_in), .reg_we_in(reg_we_in),
    .addr_out(addr_out), .io_active(io_active), .wr_active(wr_active),
    .ext_out(ext_out), .int_in_bus(int_in_bus), .rin_bus(rin_bus),
    .stall(stall), .pc_inc_out(pc_inc_out), .reg_we_out(reg_we_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int  mdl_mem [256];
  bit  mdl_known [256];
  int  mdl_ext = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs are already set after a falling edge
  task automatic step();
    int a, win, rd_ok, intin, rin, stl;
    #1;
    a   = rst ? pc_val : (addr_sel ? mptr_val : pc_val);
    win = (a >= 252);
    chk("R1 addr_out", addr_out, a);
    chk("R2 io_active", io_active, win);
    rd_ok = win || mdl_known[a];
    intin = win ? ext_in : mdl_mem[a];
    if (rd_ok) chk("R3 int_in_bus", int_in_bus, intin);
    if (rst || rin_sel == 0) rin = alu_val;
    else if (rin_sel == 1)   rin = stack_val;
    else if (rin_sel == 2)   rin = imm_val;
    else                     rin = intin;
    if (rst || rin_sel != 3 || rd_ok) chk(rst ? "R8 rin_bus" : "R4 rin_bus", rin_bus, rin);
    chk(rst ? "R8 wr_active" : "R5 wr_active", wr_active, (!rst && mem_wr && win) ? 1 : 0);
    chk(rst ? "R8 ext_out" : "R5 ext_out", ext_out, mdl_ext);
    stl = (mem_rd && win && !io_en) ? 1 : 0;
    chk("R7 stall", stall, stl);
    chk("R7 pc_inc_out", pc_inc_out, (pc_inc_in && !stl) ? 1 : 0);
    chk("R7 reg_we_out", reg_we_out, (reg_we_in && !stl) ? 1 : 0);
    @(posedge clk);
    if (rst) mdl_ext = 0;
    else if (mem_wr && win) mdl_ext = wr_data;
    else if (mem_wr) begin
      mdl_mem[a] = wr_data;
      mdl_known[a] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic setup(input bit as, input int ad, input bit wr, input bit rd,
                       input int wd, input int rs);
    addr_sel = as;
    if (as) mptr_val = 8'(ad); else pc_val = 8'(ad);
    mem_wr = wr; mem_rd = rd; wr_data = 8'(wd); rin_sel = 2'(rs);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    alu_val = 8'hA1; stack_val = 8'h5B; imm_val = 8'h3C; ext_in = 8'hE7;
    pc_inc_in = 1'b1; reg_we_in = 1'b1;
    @(negedge clk);
    // R8: reset overrides selects and writes
    setup(1'b1, 8'hFD, 1'b1, 1'b0, 8'h99, 2);
    pc_val = 8'h20;
    for (int i = 0; i < 3; i++) step();
    rst = 1'b0;
    // R6 then R3/R4: write RAM through pointer, read back next cycle
    setup(1'b1, 8'h10, 1'b1, 1'b0, 8'h6D, 0); step();
    setup(1'b1, 8'h10, 1'b0, 1'b1, 8'h00, 3); step();
    chk("R6 readback", rin_bus, 8'h6D);
    // boundary: 0xFB is RAM, 0xFC is window
    setup(1'b1, 8'hFB, 1'b1, 1'b0, 8'h42, 1); step();
    setup(1'b0, 8'hFB, 1'b0, 1'b1, 8'h00, 3); step();
    setup(1'b1, 8'hFC, 1'b1, 1'b0, 8'hC4, 2); step();
    chk("R5 ext_out after window write", ext_out, 8'hC4);
    // R7: stalled read, then coincident stall and external write
    io_en = 1'b0;
    setup(1'b1, 8'hFF, 1'b0, 1'b1, 8'h00, 3); step();
    setup(1'b1, 8'hFE, 1'b1, 1'b1, 8'h77, 3); step();
    chk("R5 ext_out written during stall", ext_out, 8'h77);
    io_en = 1'b1; ext_in = 8'h1F;
    setup(1'b1, 8'hFF, 1'b0, 1'b1, 8'h00, 3); step();
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      pc_val    = 8'($urandom);
      mptr_val  = ($urandom % 4 == 0) ? 8'(8'hFC + $urandom % 4) : 8'($urandom % 32);
      addr_sel  = 1'($urandom);
      rin_sel   = 2'($urandom);
      alu_val   = 8'($urandom); stack_val = 8'($urandom); imm_val = 8'($urandom);
      wr_data   = 8'($urandom); ext_in = 8'($urandom);
      mem_wr    = ($urandom % 3 == 0); mem_rd = 1'($urandom);
      io_en     = 1'($urandom);
      pc_inc_in = 1'($urandom); reg_we_in = 1'($urandom);
      rst       = ($urandom % 200 == 0);
      step();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule